// File: doc/BRIEF.md
# Circular Sample Store with Host-Managed Drain Pointer

This block holds converter samples in a ring whose length need not be a power of two. A producer on the converter side pushes 16-bit samples through a valid/ready port. Each accepted sample is written at the write-pointer position, and that pointer then steps forward. The pointer wraps to zero after the last slot. The host fetches samples by address through a read port with one cycle of latency. It keeps its own copy of the read pointer, and after it has drained a batch it writes the new read-pointer value into a control register.

The block works out the fill level from the two pointers. It keeps three sticky event flags: fill level at or above a programmable threshold, an illegal read-pointer write, and a sample dropped because the ring was full. A host-writable enable mask selects which flags can drive the interrupt line. Flags are cleared by writing ones.

Back-pressure: `in_ready` is high whenever reset is released. The producer is never stalled. A push that meets a full ring is discarded and reported through the overrun flag.

Top module: `sample_ring`

## Requirements
- R1: The write pointer (control address 0) and the read pointer (control address 1) always lie in 0..DEPTH-1. Each accepted push stores its sample at the write-pointer slot, and the pointer then steps by one, going from DEPTH-1 back to 0.
- R2: The fill level (control address 2) equals write pointer minus read pointer, with DEPTH added when that difference is negative. It never exceeds DEPTH-1.
- R3: The value at sample address A appears on `smp_data` one clock after A is presented. An address of DEPTH or more returns 0.
- R4: The threshold register (control address 3) resets to DEPTH/2. Flag bit 0 sets on every clock where the threshold is nonzero and the fill level is at or above it. A threshold of 0 never sets the flag.
- R5: A push while the fill level is DEPTH-1 is dropped. The write pointer and the stored data stay unchanged, and flag bit 2 sets.
- R6: A write to control address 1 is accepted only if the value is below DEPTH and lies on the arc from the current read pointer forward to the write pointer, both ends included. Any other value leaves the read pointer unchanged and sets flag bit 1.
- R7: The flag word (control address 5, bits 2..0) is sticky. Writing 1 to a bit clears it, and writing 0 leaves it alone. A set condition in the same clock as a clear wins.
- R8: `irq` is the registered OR of flag AND mask, so it follows the flags and mask one clock later.
- R9: The mask register (control address 4, bits 2..0, one bit per flag) resets to 0. While it is 0, `irq` stays low.
- R10: `in_ready` is high whenever `rst_n` is high, including while the ring is full. Unused control addresses (6 and 7) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer sample valid |
| in_ready | output | 1 | Producer ready, high out of reset |
| in_data | input | DW | Producer sample |
| smp_addr | input | AW | Host sample read address |
| smp_data | output | DW | Sample read data, one cycle after address |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | 3 | Control register address |
| cfg_wdata | input | DW | Control register write data |
| cfg_rdata | output | DW | Control register read data (combinational) |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench uses a ring of seven slots, so that wrap and full cases come up often. It sweeps every start position against every fill count, which exposes a design that wraps at a power of two or computes the level without adding DEPTH; such a design would report a huge fill level or read stale slots after a wrap. Every read-pointer candidate is tried against a partly filled ring, including out-of-range values. A design that checks the arc wrongly would move the pointer backward and lose or repeat samples. Pushes at the full level, and set-versus-clear collisions on the flags, are checked at the exact clock they take effect. A design that overwrote on overflow, or that let a clear win, would lose data or miss an interrupt that should have stayed pending.

// File: rtl/sample_ring_pkg.sv
package sample_ring_pkg;
  typedef enum logic [2:0] {
    RA_FRONT  = 3'd0,
    RA_REAR   = 3'd1,
    RA_LEVEL  = 3'd2,
    RA_THRESH = 3'd3,
    RA_MASK   = 3'd4,
    RA_FLAGS  = 3'd5
  } reg_addr_e;

  localparam int FLAG_W    = 3;
  localparam int FLG_THR   = 0;
  localparam int FLG_SWERR = 1;
  localparam int FLG_HWERR = 2;
endpackage

// File: rtl/sample_ring_store.sv
module sample_ring_store #(
  parameter int DEPTH = 2003,
  parameter int DW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rd_data <= '0;
    else if (rd_idx <= LAST) rd_data <= mem[rd_idx];
    else                    rd_data <= '0;
  end

  // write index never leaves the ring (R1)
  p_wr_in_ring_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx <= LAST));

  // out-of-ring read address yields zero next cycle (R3)
  p_oob_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx > LAST) |=> (rd_data == '0));
endmodule

// File: rtl/sample_ring_ptrs.sv
module sample_ring_ptrs #(
  parameter int DEPTH = 2003,
  parameter int DW    = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          rear_we,
  input  logic [DW-1:0] rear_wdata,
  output logic [AW-1:0] front,
  output logic [AW-1:0] rear,
  output logic [AW-1:0] level,
  output logic          push_ok,
  output logic          hw_err,
  output logic          sw_err
);
  localparam logic [AW:0]   DEPTH_X = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] ring_dist(input logic [AW-1:0] hi,
                                              input logic [AW-1:0] lo);
    logic [AW:0] t;
    if (hi >= lo) t = {1'b0, hi} - {1'b0, lo};
    else          t = {1'b0, hi} + DEPTH_X - {1'b0, lo};
    return AW'(t);
  endfunction

  logic          full;
  logic          cand_in_range;
  logic          rear_ok;
  logic [AW-1:0] cand;
  logic [AW-1:0] cand_level;

  always_comb begin
    level         = ring_dist(front, rear);
    full          = (level == LAST);
    push_ok       = push_req && !full;
    hw_err        = push_req && full;
    cand_in_range = (rear_wdata < DW'(DEPTH));
    cand          = AW'(rear_wdata);
    cand_level    = ring_dist(front, cand);
    rear_ok       = cand_in_range && (cand_level <= level);
    sw_err        = rear_we && !rear_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      front <= '0;
    end else if (push_ok) begin
      front <= (front == LAST) ? '0 : front + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rear <= '0;
    end else if (rear_we && rear_ok) begin
      rear <= cand;
    end
  end

  p_front_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    front <= LAST);
  p_rear_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rear <= LAST);
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LAST);
  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_err |=> $stable(front));
  p_rear_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_err |=> $stable(rear));
endmodule

// File: rtl/sample_ring_flags.sv
module sample_ring_flags
  import sample_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_bits,
  input  logic              mask_we,
  input  logic [FLAG_W-1:0] mask_wdata,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] mask,
  output logic              irq
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   flags[i] <= 1'b0;
      else if (set_vec[i])          flags[i] <= 1'b1;
      else if (clr_we && clr_bits[i]) flags[i] <= 1'b0;
    end

    // a flag only drops on an explicit one-write (R7)
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !(clr_we && clr_bits[i])) |=> flags[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flags & mask);
  end

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(flags & mask)));
  p_mask_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> !irq);
endmodule

// File: rtl/sample_ring.sv
module sample_ring
  import sample_ring_pkg::*;
#(
  parameter int DEPTH     = 2003,
  parameter int DW        = 16,
  parameter int THR_RESET = DEPTH / 2,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [AW-1:0] smp_addr,
  output logic [DW-1:0] smp_data,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          irq
);
  logic [AW-1:0]     front, rear, level, thresh;
  logic              push_req, push_ok, hw_err, sw_err, thr_hit;
  logic              we_rear, we_thresh, we_mask, we_flags;
  logic [FLAG_W-1:0] flags, mask, set_vec;

  assign in_ready  = rst_n;
  assign push_req  = in_valid && in_ready;
  assign we_rear   = cfg_we && (cfg_addr == RA_REAR);
  assign we_thresh = cfg_we && (cfg_addr == RA_THRESH);
  assign we_mask   = cfg_we && (cfg_addr == RA_MASK);
  assign we_flags  = cfg_we && (cfg_addr == RA_FLAGS);

  sample_ring_ptrs #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (push_req),
    .rear_we    (we_rear),
    .rear_wdata (cfg_wdata),
    .front      (front),
    .rear       (rear),
    .level      (level),
    .push_ok    (push_ok),
    .hw_err     (hw_err),
    .sw_err     (sw_err)
  );

  sample_ring_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push_ok),
    .wr_idx  (front),
    .wr_data (in_data),
    .rd_idx  (smp_addr),
    .rd_data (smp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         thresh <= AW'(THR_RESET);
    else if (we_thresh) thresh <= AW'(cfg_wdata);
  end

  always_comb begin
    thr_hit              = (thresh != '0) && (level >= thresh);
    set_vec              = '0;
    set_vec[FLG_THR]     = thr_hit;
    set_vec[FLG_SWERR]   = sw_err;
    set_vec[FLG_HWERR]   = hw_err;
  end

  sample_ring_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .clr_we     (we_flags),
    .clr_bits   (cfg_wdata[FLAG_W-1:0]),
    .mask_we    (we_mask),
    .mask_wdata (cfg_wdata[FLAG_W-1:0]),
    .flags      (flags),
    .mask       (mask),
    .irq        (irq)
  );

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RA_FRONT:  cfg_rdata = DW'(front);
      RA_REAR:   cfg_rdata = DW'(rear);
      RA_LEVEL:  cfg_rdata = DW'(level);
      RA_THRESH: cfg_rdata = DW'(thresh);
      RA_MASK:   cfg_rdata = DW'(mask);
      RA_FLAGS:  cfg_rdata = DW'(flags);
      default:   cfg_rdata = '0;
    endcase
  end

  p_thresh_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    thr_hit |=> flags[FLG_THR]);
  p_overrun_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_err |=> flags[FLG_HWERR]);
  p_badrear_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_err |=> flags[FLG_SWERR]);
endmodule

// File: tb/sample_ring_bench.sv
`timescale 1ns/1ps
module sample_ring_bench;
  localparam int D  = 7;
  localparam int DW = 16;
  localparam int AW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic [AW-1:0] smp_addr = '0;
  logic [DW-1:0] smp_data;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  int ef = 0;
  int er = 0;
  int mdl [D];
  logic [DW-1:0] v;

  always #10 clk = ~clk;

  sample_ring #(.DEPTH(D), .DW(DW)) u_sample_ring (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .smp_addr(smp_addr), .smp_data(smp_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int val);
    @(negedge clk); in_valid = 1'b1; in_data = DW'(val);
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic wreg(input int a, input int d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = DW'(d);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rreg(input int a, output logic [DW-1:0] r);
    cfg_addr = 3'(a); #2; r = cfg_rdata;
  endtask

  task automatic rsmp(input int a, output logic [DW-1:0] r);
    smp_addr = AW'(a); @(negedge clk); r = smp_data;
  endtask

  task automatic push_m(input int val);
    push(val); mdl[ef] = val; ef = (ef + 1) % D;
  endtask

  task automatic drain();
    wreg(1, ef); er = ef;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rreg(0, v); chk("R1 reset front", int'(v), 0);
    rreg(1, v); chk("R1 reset rear", int'(v), 0);
    rreg(2, v); chk("R2 reset level", int'(v), 0);
    rreg(3, v); chk("R4 reset threshold", int'(v), D / 2);
    rreg(4, v); chk("R9 reset mask", int'(v), 0);
    rreg(5, v); chk("R7 reset flags", int'(v), 0);
    rreg(6, v); chk("R10 unused address", int'(v), 0);
    chk("R8 reset irq", int'(irq), 0);
    chk("R10 ready after reset", int'(in_ready), 1);
    wreg(3, 0);

    // sweep: every start position x every fill count
    for (int s = 0; s < D; s++) begin
      for (int n = 0; n < D; n++) begin
        while (ef != s) begin push_m(16'hF000); drain(); end
        for (int i = 0; i < n; i++) push_m(16'h0100 * s + 16 * n + i);
        rreg(2, v); chk("R2 level", int'(v), n);
        rreg(0, v); chk("R1 front wrap", int'(v), (s + n) % D);
        for (int i = 0; i < n; i++) begin
          rsmp((s + i) % D, v);
          chk("R3 sample data", int'(v), mdl[(s + i) % D]);
        end
        if (n == D - 1) begin
          rreg(5, v); chk("R4 zero threshold never sets", int'(v[0]), 0);
          chk("R10 ready while full", int'(in_ready), 1);
        end
        drain();
        rreg(5, v); chk("R6 legal drain no error", int'(v[1]), 0);
        rreg(1, v); chk("R6 legal drain accepted", int'(v), ef);
      end
    end
    rsmp(7, v); chk("R3 out-of-ring address", int'(v), 0);

    // read pointer candidate legality
    for (int k = 0; k < 9; k++) begin
      int c;
      bit ok;
      drain();
      for (int i = 0; i < 3; i++) push_m(16'h0A00 + i);
      c  = (k < D) ? (er + k) % D : k;
      ok = (k <= 3);
      wreg(1, c);
      rreg(1, v); chk("R6 rear after candidate", int'(v), ok ? c : er);
      rreg(5, v); chk("R6 error flag", int'(v[1]), ok ? 0 : 1);
      if (ok) er = c;
      wreg(5, 2);
      rreg(5, v); chk("R7 one-write clears", int'(v[1]), 0);
    end

    // overflow drop
    drain();
    for (int i = 0; i < D - 1; i++) push_m(16'h0B00 + i);
    rreg(2, v); chk("R5 level at full", int'(v), D - 1);
    push(16'hDEAD);
    rreg(5, v); chk("R5 overrun flag", int'(v[2]), 1);
    rreg(2, v); chk("R5 level unchanged", int'(v), D - 1);
    rreg(0, v); chk("R5 front unchanged", int'(v), ef);
    for (int i = 0; i < D; i++) begin
      rsmp(i, v); chk("R5 storage unchanged", int'(v), mdl[i]);
    end
    wreg(5, 0);
    rreg(5, v); chk("R7 zero-write keeps flag", int'(v[2]), 1);
    wreg(5, 4);
    rreg(5, v); chk("R7 clear overrun", int'(v), 0);

    // threshold, mask and interrupt timing
    drain();
    wreg(3, 4);
    for (int i = 0; i < 3; i++) push_m(i);
    @(negedge clk);
    rreg(5, v); chk("R4 below threshold", int'(v[0]), 0);
    push_m(3);
    @(negedge clk);
    rreg(5, v); chk("R4 at threshold", int'(v[0]), 1);
    chk("R9 masked irq low", int'(irq), 0);
    wreg(4, 1);
    chk("R8 irq one cycle late", int'(irq), 0);
    @(negedge clk);
    chk("R8 irq raised", int'(irq), 1);
    wreg(5, 1);
    rreg(5, v); chk("R7 set wins over clear", int'(v[0]), 1);
    drain();
    wreg(5, 1);
    rreg(5, v); chk("R7 cleared after drain", int'(v), 0);
    chk("R8 irq held one cycle", int'(irq), 1);
    @(negedge clk);
    chk("R8 irq dropped", int'(irq), 0);
    rreg(4, v); chk("R9 mask readback", int'(v), 1);
    push_m(9); push_m(9); push_m(9); push_m(9);
    wreg(4, 0);
    repeat (2) @(negedge clk);
    chk("R9 zero mask blocks irq", int'(irq), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule